// File: doc/BRIEF.md
# I2C Master Control Sequencer

This block is the control core of an I2C interface. It sits between a CPU register port and a bit-level engine that drives SCL and SDA. Software writes one control register. That register holds a master-select bit, a write-only repeated-start bit, an acknowledge enable, a bus-error interrupt enable, an interrupt-pending flag and a bus-error flag.

Writes to that register become start, repeated-start and stop commands for the engine. Each command is a single-cycle pulse. The engine reports four events back to the block: byte completion, arbitration loss, bus errors and slave addressing. The block turns them into status bits, an interrupt and an SCL hold request.

A start requested while the bus is in use is held until the bus is free. It is dropped if, in the meantime, the interface is addressed as a slave that must transmit. Stop and repeated start are accepted only in one state: master mode with the interrupt flag set. Each of them also clears that flag.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset, every control bit, status flag and command output is 0.
- R2: A write with bit 0 = 1 while master-select is 0, no start is pending and the bus is idle sets master-select and pulses `cmd_start` for one cycle. The pulse appears in the cycle after the write.
- R3: A write with bit 0 = 0 while master-select = 1 and the interrupt flag = 1 does three things: it clears both bits, it pulses `cmd_stop`, and it leaves the bus-busy status bit (stat bit 0) following `eng_bus_busy` until the engine reports the bus free.
- R4: A write with bit 0 = 1 and bit 1 = 1 while master-select = 1 and the interrupt flag = 1 pulses `cmd_rstart` and clears the interrupt flag. Control read bit 1 always reads 0.
- R5: A start write made while the bus is busy and `eng_trx` = 0 is held pending. The start (`cmd_start` plus master-select set) is issued in the cycle after the first clock edge at which the bus is seen idle.
- R6: While a start is pending, being addressed as a slave receiver keeps it pending. Being addressed as a slave transmitter (`eng_addr_match` = 1 and `eng_slave_tx` = 1) cancels it, so no start follows when the bus frees.
- R7: `eng_arb_lost` clears master-select and sets the arbitration-lost status bit (stat bit 1) and the interrupt flag.
- R8: `eng_byte_done` sets the interrupt flag (control bit 4). `scl_hold` equals that flag. A write with bit 4 = 0 clears both the interrupt flag and arbitration-lost.
- R9: Control bit 2 is the acknowledge enable. It is written on every write and drives `ack_drive_en`.
- R10: `eng_bus_err` sets the bus-error flag (control bit 5). A write with bit 5 = 0 clears it. `irq` is the interrupt flag OR'd with the bus-error flag, and the bus-error term counts only when control bit 3 = 1.
- R11: Action writes outside the allowed combinations produce no command and change neither master-select nor the interrupt flag. These are: a stop or repeated start without the interrupt flag, and a start while the bus is busy with `eng_trx` = 1.
- R12: An engine event that sets a flag wins over a software clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control read: {2'b0, bus error, irq flag, berr irq enable, ack enable, 0, master-select} |
| stat_rdata | output | 4 | Status read: {trx, addressed, arb lost, bus busy} |
| eng_bus_busy | input | 1 | Engine: bus between start and stop |
| eng_trx | input | 1 | Engine: interface currently transmitting |
| eng_addr_match | input | 1 | Engine: addressed as slave |
| eng_slave_tx | input | 1 | Engine: slave access is a read (slave transmits) |
| eng_byte_done | input | 1 | Engine: byte transfer finished (pulse) |
| eng_arb_lost | input | 1 | Engine: arbitration lost (pulse) |
| eng_bus_err | input | 1 | Engine: bus error detected (pulse) |
| cmd_start | output | 1 | Issue start and send address byte (pulse) |
| cmd_rstart | output | 1 | Issue repeated start (pulse) |
| cmd_stop | output | 1 | Issue stop (pulse) |
| ack_drive_en | output | 1 | Acknowledge received data bytes |
| scl_hold | output | 1 | Hold SCL low while interrupt is pending |
| irq | output | 1 | Interrupt to the CPU |

## Verification
The embedded assertions cover four rules on every cycle:
- at most one command pulse is active at a time;
- a start never follows a cycle in which the bus was busy;
- a stop always leaves master-select clear;
- byte completion and arbitration loss always take effect in the following cycle.

Other behaviour can only be shown by the bench scenarios. These include the deferred start and its cancellation by a slave-transmit access, the ignored out-of-state writes, the masking of the bus-error interrupt and set-over-clear priority. A behavioural model compares every output against these scenarios on each clock.

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic [3:0] stat_rdata,
  input  logic       eng_bus_busy,
  input  logic       eng_trx,
  input  logic       eng_addr_match,
  input  logic       eng_slave_tx,
  input  logic       eng_byte_done,
  input  logic       eng_arb_lost,
  input  logic       eng_bus_err,
  output logic       cmd_start,
  output logic       cmd_rstart,
  output logic       cmd_stop,
  output logic       ack_drive_en,
  output logic       scl_hold,
  output logic       irq
);

  logic msel, pend, ack_en, berr_ie, irq_f, al, ber;

  wire w_msel  = ctl_wdata[0];
  wire w_rs    = ctl_wdata[1];
  wire w_irq   = ctl_wdata[4];
  wire w_ber   = ctl_wdata[5];
  wire in_mint = msel && irq_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msel <= 1'b0; pend <= 1'b0; ack_en <= 1'b0; berr_ie <= 1'b0;
      irq_f <= 1'b0; al <= 1'b0; ber <= 1'b0;
      cmd_start <= 1'b0; cmd_rstart <= 1'b0; cmd_stop <= 1'b0;
    end else begin
      cmd_start  <= 1'b0;
      cmd_rstart <= 1'b0;
      cmd_stop   <= 1'b0;
      if (ctl_we) begin
        ack_en  <= ctl_wdata[2];
        berr_ie <= ctl_wdata[3];
        if (!w_irq) begin
          irq_f <= 1'b0;
          al    <= 1'b0;
        end
        if (!w_ber) ber <= 1'b0;
        if (in_mint && !w_msel) begin
          msel     <= 1'b0;
          irq_f    <= 1'b0;
          cmd_stop <= 1'b1;
        end else if (in_mint && w_rs) begin
          irq_f      <= 1'b0;
          cmd_rstart <= 1'b1;
        end else if (!msel && !pend && w_msel) begin
          if (!eng_bus_busy) begin
            msel      <= 1'b1;
            cmd_start <= 1'b1;
          end else if (!eng_trx) begin
            pend <= 1'b1;
          end
        end
      end
      if (pend) begin
        if (eng_addr_match && eng_slave_tx) begin
          pend <= 1'b0;
        end else if (!eng_bus_busy) begin
          pend      <= 1'b0;
          msel      <= 1'b1;
          cmd_start <= 1'b1;
        end
      end
      if (eng_byte_done) irq_f <= 1'b1;
      if (eng_bus_err)   ber   <= 1'b1;
      if (eng_arb_lost) begin
        irq_f <= 1'b1;
        al    <= 1'b1;
        msel  <= 1'b0;
      end
    end
  end

  assign ctl_rdata    = {2'b00, ber, irq_f, berr_ie, ack_en, 1'b0, msel};
  assign stat_rdata   = {eng_trx, eng_addr_match, al, eng_bus_busy};
  assign ack_drive_en = ack_en;
  assign scl_hold     = irq_f;
  assign irq          = irq_f | (ber & berr_ie);

  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_start, cmd_rstart, cmd_stop}));

  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !$past(eng_bus_busy));

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> !ctl_rdata[0]);

  assert_arb_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_arb_lost |=> (!ctl_rdata[0] && stat_rdata[1] && scl_hold));

  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_byte_done |=> irq);

endmodule

// File: tb/i2c_ctl_seq_tb.sv
module i2c_ctl_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [3:0] stat_rdata;
  logic busy = 1'b0, trx = 1'b0, amatch = 1'b0, stx = 1'b0;
  logic bdone = 1'b0, alost = 1'b0, berr = 1'b0;
  logic cmd_start, cmd_rstart, cmd_stop, ack_drive_en, scl_hold, irq;

  int total = 0, bad = 0;
  string cur = "R1";

  always #4 clk = ~clk;

  i2c_ctl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
    .eng_bus_busy(busy), .eng_trx(trx), .eng_addr_match(amatch),
    .eng_slave_tx(stx), .eng_byte_done(bdone), .eng_arb_lost(alost),
    .eng_bus_err(berr), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
    .cmd_stop(cmd_stop), .ack_drive_en(ack_drive_en), .scl_hold(scl_hold),
    .irq(irq));

  bit m_ms, m_pd, m_ack, m_ie, m_if, m_al, m_be, m_st, m_rs, m_sp;

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit start_ok, stop_ok, rs_ok;
    m_st = 0; m_rs = 0; m_sp = 0;
    if (!rst_n) begin
      {m_ms, m_pd, m_ack, m_ie, m_if, m_al, m_be} = '0;
    end else begin
      stop_ok  = ctl_we && m_ms && m_if && !ctl_wdata[0];
      rs_ok    = ctl_we && m_ms && m_if && ctl_wdata[0] && ctl_wdata[1];
      start_ok = ctl_we && !m_ms && !m_pd && ctl_wdata[0];
      if (ctl_we) begin
        m_ack = ctl_wdata[2];
        m_ie  = ctl_wdata[3];
        if (ctl_wdata[4] == 0) begin m_if = 0; m_al = 0; end
        if (ctl_wdata[5] == 0) m_be = 0;
      end
      if (stop_ok) begin m_ms = 0; m_if = 0; m_sp = 1; end
      else if (rs_ok) begin m_if = 0; m_rs = 1; end
      else if (start_ok) begin
        if (!busy) begin m_ms = 1; m_st = 1; end
        else if (!trx) m_pd = 1;
      end
      else if (m_pd) begin
        if (amatch && stx) m_pd = 0;
        else if (!busy) begin m_pd = 0; m_ms = 1; m_st = 1; end
      end
      if (bdone) m_if = 1;
      if (berr) m_be = 1;
      if (alost) begin m_if = 1; m_al = 1; m_ms = 0; end
    end
    #2;
    chk("ctl_rdata", ctl_rdata, {2'b0, m_be, m_if, m_ie, m_ack, 1'b0, m_ms});
    chk("stat_rdata", stat_rdata, {trx, amatch, m_al, busy});
    chk("cmd_start", cmd_start, m_st);
    chk("cmd_rstart", cmd_rstart, m_rs);
    chk("cmd_stop", cmd_stop, m_sp);
    chk("ack_drive_en", ack_drive_en, m_ack);
    chk("scl_hold", scl_hold, m_if);
    chk("irq", irq, m_if | (m_be & m_ie));
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur = "R1"; idle(3); rst_n = 1; idle(2);
    cur = "R9"; wr(8'h3C); idle(2);
    cur = "R10"; pulse(berr); idle(2); wr(8'h1C); idle(1);
    wr(8'h34); pulse(berr); idle(2); wr(8'h14); idle(1);
    cur = "R2"; wr(8'h31); busy = 1; idle(2);
    cur = "R8"; pulse(bdone); idle(2);
    cur = "R4"; wr(8'h33); idle(2); pulse(bdone); idle(1);
    cur = "R3"; wr(8'h30); idle(3); busy = 0; idle(2);
    cur = "R11"; wr(8'h31); busy = 1; idle(1);
    wr(8'h30); idle(1); wr(8'h33); idle(2);
    cur = "R7"; pulse(alost); idle(2);
    cur = "R8"; wr(8'h20); idle(2); busy = 0; idle(1);
    cur = "R5"; busy = 1; wr(8'h31); idle(4); busy = 0; idle(2);
    busy = 1; pulse(bdone); wr(8'h30); busy = 0; idle(2);
    cur = "R11"; busy = 1; trx = 1; wr(8'h31); idle(1);
    busy = 0; trx = 0; idle(3);
    cur = "R6"; busy = 1; wr(8'h31); amatch = 1; idle(3);
    amatch = 0; busy = 0; idle(2);
    busy = 1; pulse(bdone); wr(8'h30); busy = 0; idle(2);
    busy = 1; wr(8'h31); amatch = 1; stx = 1; idle(2);
    amatch = 0; stx = 0; busy = 0; idle(3);
    cur = "R12"; pulse(bdone);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h20; bdone = 1;
    @(negedge clk); ctl_we = 0; bdone = 0; idle(2);
    wr(8'h24); idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule